// File: doc/BRIEF.md
# Modem Control Register Block with Detect Interrupts

This block is the processor-facing register set of a modem controller. The processor drives an 8-bit multiplexed bus. A pulse on `ale` captures the low three bits of the shared lines as the register address. After that, single-cycle `wr_en` or `rd_en` pulses move data to or from the selected register. Three registers are plain storage: two control bytes and a tone-select byte. Their contents also drive the rest of the modem through dedicated outputs.

The fourth register reports the state of five monitored conditions:

- carrier present
- call-progress tone
- answer tone
- long loop (weak received signal)
- unscrambled mark

These conditions arrive as digital levels from the receive path. Each is synchronized through two flops. The mark condition is further qualified by a counter, so it is reported only after the raw receive data has stayed high for a long, parameterized interval.

Any change of a condition other than long loop raises a level interrupt, provided the enable-interrupt control bit is set. The interrupt stays high until the processor reads the detect register.

Top module: `modem_ctl_regs`

## Requirements
- R1: The address is taken from `ad_in[2:0]` on the cycle `ale` is high. The map is: 0 = control A, 1 = control B, 2 = detect, 3 = tone. Reads of addresses 4 to 7 return 0x00, and writes to them are ignored.
- R2: A `wr_en` pulse to address 0, 1 or 3 stores `ad_in` in that register. A later read returns the stored byte, and the register's output port shows it.
- R3: A `rd_en` pulse puts the selected register on `ad_out` in the next cycle, with `ad_oe` high for exactly that one cycle.
- R4: The detect register is read-only. A write to address 2 changes neither its contents nor `irq`.
- R5: After reset, every register reads 0x00 and `irq` and `ad_oe` are low.
- R6: Detect layout: bit 0 long loop, bit 1 carrier, bit 2 answer tone, bit 3 call-progress tone, bit 4 unscrambled mark, bits 7:5 zero. Each bit follows its synchronized input within three clock cycles of a change.
- R7: With the enable bit (control B bit 7) at 1, a change in carrier, answer tone, call-progress tone or mark sets `irq` high, and `irq` stays high.
- R8: A change in long loop updates detect bit 0 but never raises `irq`.
- R9: With the enable bit at 0, changes do not set `irq`, and they stay lost after a later enable. Clearing the enable bit drops `irq` on the following cycle.
- R10: A read of the detect register clears `irq`, unless an enabled change arrives in the same cycle.
- R11: Detect bit 4 becomes 1 only after the synchronized `rxmark_in` has been high for `MARK_CYCLES` consecutive cycles. It returns to 0 once that input goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address latch strobe; captures ad_in[2:0] |
| wr_en | input | 1 | Write strobe for the latched address |
| rd_en | input | 1 | Read strobe for the latched address |
| ad_in | input | 8 | Shared address/data lines, processor to block |
| ad_out | output | 8 | Read data, registered |
| ad_oe | output | 1 | High for the cycle ad_out carries read data |
| carrier_in | input | 1 | Carrier present level |
| cpt_in | input | 1 | Call-progress tone level |
| answer_in | input | 1 | Answer tone level |
| lloop_in | input | 1 | Long loop (weak signal) level |
| rxmark_in | input | 1 | Raw receive data ahead of the descrambler |
| ctrl_a | output | 8 | Control register A contents |
| ctrl_b | output | 8 | Control register B contents (bit 7 enables interrupts) |
| tone | output | 8 | Tone register contents |
| irq | output | 1 | Active-high level interrupt |

## Verification
The assertions assume that `ale`, `wr_en` and `rd_en` are never high in the same cycle. They also assume that a strobe uses an address latched in an earlier cycle. The bench always issues the latch cycle first, then a separate single-cycle data strobe. The clearing checks assume no enabled source changes in the cycle of the detect read. The bench therefore holds every status input still while it reads or writes registers, and only moves a status input when it has no bus access in flight.

// File: rtl/modem_regs_pkg.sv
package modem_regs_pkg;

  // register addresses (decoded on the full latched field)
  localparam int REG_CTRL_A = 0;
  localparam int REG_CTRL_B = 1;
  localparam int REG_DETECT = 2;
  localparam int REG_TONE   = 3;

  // detect register bit positions
  localparam int DET_LLOOP   = 0;
  localparam int DET_CARRIER = 1;
  localparam int DET_ANSWER  = 2;
  localparam int DET_CPT     = 3;
  localparam int DET_MARK    = 4;
  localparam int NUM_STAT    = 5;

  // interrupt enable position inside control B
  localparam int IEN_BIT = 7;

  // sources that may raise the interrupt (all except long loop)
  localparam logic [NUM_STAT-1:0] IRQ_SRC_MASK = 5'b11110;

  typedef struct packed {
    logic mark;
    logic cpt;
    logic answer;
    logic carrier;
    logic lloop;
  } stat_t;

endpackage

// File: rtl/modem_status_sync.sv
module modem_status_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/modem_mark_qual.sv
module modem_mark_qual #(
  parameter int MARK_CYCLES = 33_100_000
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic mark_q
);

  localparam int CNT_W = $clog2(MARK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MARK_CYCLES);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_next;

  always_comb begin
    if (!din)               cnt_next = '0;
    else if (cnt == LIMIT)  cnt_next = cnt;
    else                    cnt_next = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      mark_q <= 1'b0;
    end else begin
      cnt    <= cnt_next;
      mark_q <= din && (cnt_next == LIMIT);
    end
  end

endmodule

// File: rtl/modem_detect_unit.sv
module modem_detect_unit #(
  parameter int             NUM_SRC  = 5,
  parameter logic [NUM_SRC-1:0] IRQ_MASK = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] lvl_in,
  input  logic               ien,
  input  logic               clr_rd,
  output logic [NUM_SRC-1:0] lvl_q,
  output logic [NUM_SRC-1:0] chg,
  output logic               irq
);

  logic irq_evt;

  assign chg     = lvl_in ^ lvl_q;
  assign irq_evt = |(chg & IRQ_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      irq   <= 1'b0;
    end else begin
      lvl_q <= lvl_in;
      if (irq_evt && ien)      irq <= 1'b1;
      else if (clr_rd || !ien) irq <= 1'b0;
    end
  end

endmodule

// File: rtl/modem_reg_bank.sv
module modem_reg_bank
  import modem_regs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [DATA_W-1:0] detect_val,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] ctrl_a,
  output logic [DATA_W-1:0] ctrl_b,
  output logic [DATA_W-1:0] tone,
  output logic              det_rd
);

  localparam logic [ADDR_W-1:0] AD_CA  = ADDR_W'(REG_CTRL_A);
  localparam logic [ADDR_W-1:0] AD_CB  = ADDR_W'(REG_CTRL_B);
  localparam logic [ADDR_W-1:0] AD_DET = ADDR_W'(REG_DETECT);
  localparam logic [ADDR_W-1:0] AD_TN  = ADDR_W'(REG_TONE);

  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (ale) addr_q <= ad_in[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_a <= '0;
      ctrl_b <= '0;
      tone   <= '0;
    end else if (wr_en) begin
      case (addr_q)
        AD_CA:   ctrl_a <= ad_in;
        AD_CB:   ctrl_b <= ad_in;
        AD_TN:   tone   <= ad_in;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_q)
      AD_CA:   rd_mux = ctrl_a;
      AD_CB:   rd_mux = ctrl_b;
      AD_DET:  rd_mux = detect_val;
      AD_TN:   rd_mux = tone;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out <= '0;
      ad_oe  <= 1'b0;
    end else begin
      ad_oe <= rd_en;
      if (rd_en) ad_out <= rd_mux;
    end
  end

  assign det_rd = rd_en && (addr_q == AD_DET);

endmodule

// File: rtl/modem_ctl_regs.sv
module modem_ctl_regs
  import modem_regs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int MARK_CYCLES = 33_100_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic              carrier_in,
  input  logic              cpt_in,
  input  logic              answer_in,
  input  logic              lloop_in,
  input  logic              rxmark_in,
  output logic [DATA_W-1:0] ctrl_a,
  output logic [DATA_W-1:0] ctrl_b,
  output logic [DATA_W-1:0] tone,
  output logic              irq
);

  stat_t               raw;
  logic [NUM_STAT-1:0] sync_v;
  logic                mark_q;
  logic [NUM_STAT-1:0] lvl_in;
  logic [NUM_STAT-1:0] det_lvl;
  logic [NUM_STAT-1:0] chg;
  logic [ADDR_W-1:0]   addr_q;
  logic                det_rd;
  logic [DATA_W-1:0]   detect_val;

  always_comb begin
    raw         = '0;
    raw.lloop   = lloop_in;
    raw.carrier = carrier_in;
    raw.answer  = answer_in;
    raw.cpt     = cpt_in;
    raw.mark    = rxmark_in;
  end

  modem_status_sync #(.WIDTH(NUM_STAT), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw),
    .dout(sync_v)
  );

  modem_mark_qual #(.MARK_CYCLES(MARK_CYCLES)) u_mark (
    .clk   (clk),
    .rst   (rst),
    .din   (sync_v[DET_MARK]),
    .mark_q(mark_q)
  );

  always_comb begin
    lvl_in           = sync_v;
    lvl_in[DET_MARK] = mark_q;
  end

  modem_detect_unit #(.NUM_SRC(NUM_STAT), .IRQ_MASK(IRQ_SRC_MASK)) u_det (
    .clk   (clk),
    .rst   (rst),
    .lvl_in(lvl_in),
    .ien   (ctrl_b[IEN_BIT]),
    .clr_rd(det_rd),
    .lvl_q (det_lvl),
    .chg   (chg),
    .irq   (irq)
  );

  assign detect_val = DATA_W'(det_lvl);

  modem_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .ale       (ale),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .ad_in     (ad_in),
    .detect_val(detect_val),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .addr_q    (addr_q),
    .ctrl_a    (ctrl_a),
    .ctrl_b    (ctrl_b),
    .tone      (tone),
    .det_rd    (det_rd)
  );

endmodule

// File: rtl/modem_ctl_regs_chk.sv
module modem_ctl_regs_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int NSRC   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] ad_in,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] ctrl_a,
  input logic [DATA_W-1:0] ctrl_b,
  input logic              irq,
  input logic [NSRC-1:0]   chg,
  input logic [NSRC-1:0]   det_lvl,
  input logic              det_rd,
  input logic              mark_q,
  input logic [NSRC-1:0]   sync_v
);

  // R9
  ien_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_b[7] |=> !irq);

  // R7 R8
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq && chg[NSRC-1:1] == '0) |=> !irq);

  // R10
  det_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (det_rd && chg[NSRC-1:1] == '0) |=> !irq);

  // R11
  mark_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mark_q) |-> $past(sync_v[NSRC-1]));

  // R2
  ctrl_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_q == ADDR_W'(0)) |=> ctrl_a == $past(ad_in));

  // R4
  det_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_q == ADDR_W'(2) && chg == '0) |=> $stable(det_lvl));

endmodule

bind modem_ctl_regs modem_ctl_regs_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NSRC(modem_regs_pkg::NUM_STAT)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .ad_in  (ad_in),
  .addr_q (addr_q),
  .ctrl_a (ctrl_a),
  .ctrl_b (ctrl_b),
  .irq    (irq),
  .chg    (chg),
  .det_lvl(det_lvl),
  .det_rd (det_rd),
  .mark_q (mark_q),
  .sync_v (sync_v)
);

// File: tb/test_modem_ctl_regs.sv
module test_modem_ctl_regs;

  localparam int MARK_N = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ale = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] ad_in = '0;
  logic [7:0] ad_out;
  logic       ad_oe;
  logic       carrier_in = 0, cpt_in = 0, answer_in = 0, lloop_in = 0, rxmark_in = 0;
  logic [7:0] ctrl_a, ctrl_b, tone;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] model [4];

  always #2.5 clk = ~clk;

  modem_ctl_regs #(.MARK_CYCLES(MARK_N)) i_modem_ctl_regs (
    .clk(clk), .rst(rst), .ale(ale), .wr_en(wr_en), .rd_en(rd_en),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .carrier_in(carrier_in), .cpt_in(cpt_in), .answer_in(answer_in),
    .lloop_in(lloop_in), .rxmark_in(rxmark_in),
    .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .tone(tone), .irq(irq)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a, input logic [7:0] det);
    case (a)
      3'd0: return model[0];
      3'd1: return model[1];
      3'd2: return det;
      3'd3: return model[3];
      default: return 8'h00;
    endcase
  endfunction

  task automatic latch(input logic [2:0] a);
    @(negedge clk); ale = 1'b1; ad_in = {5'b0, a};
    @(negedge clk); ale = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    latch(a);
    wr_en = 1'b1; ad_in = d;
    @(negedge clk); wr_en = 1'b0;
    if (a == 3'd0 || a == 3'd1 || a == 3'd3) model[a[1:0]] = d;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    latch(a);
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    d = ad_out;
    check(ad_oe === 1'b1, "R3 oe high", ad_oe, 1);
    @(negedge clk);
    check(ad_oe === 1'b0, "R3 oe one cycle", ad_oe, 0);
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    rd(a, d);
    check(d === exp, tag, d, exp);
  endtask

  task automatic settle;
    repeat (6) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    logic [7:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R5 reset state
    check(irq === 1'b0 && ad_oe === 1'b0, "R5 irq/oe after reset", {irq, ad_oe}, 0);
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 8'h00, "R5 reset read");

    // R1 R2 R4 random register traffic, status inputs idle
    for (int i = 0; i < 80; i++) begin
      logic [2:0] a;
      logic [7:0] v;
      a = 3'($urandom_range(0, 7));
      v = 8'($urandom);
      if ($urandom_range(0, 1) == 1) wr(a, v);
      else begin
        rd(a, d);
        check(d === exp_read(a, 8'h00), "R1 R2 R4 random read", d, exp_read(a, 8'h00));
      end
    end
    check(ctrl_a === model[0] && ctrl_b === model[1] && tone === model[3],
          "R2 register outputs", {ctrl_a, ctrl_b, tone}, {model[0], model[1], model[3]});
    check(irq === 1'b0, "R4 irq quiet without status change", irq, 0);

    // directed: enable interrupts, carrier change
    wr(3'd1, 8'h80);
    carrier_in = 1'b1; settle();
    check(irq === 1'b1, "R7 carrier raises irq", irq, 1);
    rd_chk(3'd2, 8'h02, "R6 carrier bit 1");
    check(irq === 1'b0, "R10 detect read clears irq", irq, 0);

    // long loop: bit set, no irq
    lloop_in = 1'b1; settle();
    check(irq === 1'b0, "R8 long loop no irq", irq, 0);
    rd_chk(3'd2, 8'h03, "R8 long loop bit 0");

    // R4 write to detect ignored
    wr(3'd2, 8'hFF);
    rd_chk(3'd2, 8'h03, "R4 detect write ignored");
    check(irq === 1'b0, "R4 detect write no irq", irq, 0);

    // R9 masked change
    wr(3'd1, 8'h00);
    answer_in = 1'b1; settle();
    check(irq === 1'b0, "R9 masked answer tone", irq, 0);
    rd_chk(3'd2, 8'h07, "R6 answer bit 2");
    wr(3'd1, 8'h80); settle();
    check(irq === 1'b0, "R9 masked event stays lost", irq, 0);

    // call-progress, then drop enable
    cpt_in = 1'b1; settle();
    check(irq === 1'b1, "R7 cpt raises irq", irq, 1);
    repeat (3) @(negedge clk);
    check(irq === 1'b1, "R7 irq level held", irq, 1);
    wr(3'd1, 8'h00);
    @(negedge clk);
    check(irq === 1'b0, "R9 clearing enable drops irq", irq, 0);
    rd_chk(3'd2, 8'h0F, "R6 cpt bit 3");

    // R11 mark qualification
    wr(3'd1, 8'h80);
    rxmark_in = 1'b1;
    repeat (MARK_N - 20) @(negedge clk);
    rd_chk(3'd2, 8'h0F, "R11 mark not yet qualified");
    check(irq === 1'b0, "R11 no irq before qualify", irq, 0);
    repeat (30) @(negedge clk);
    check(irq === 1'b1, "R11 mark raises irq", irq, 1);
    rd_chk(3'd2, 8'h1F, "R11 mark qualified bit 4");
    rxmark_in = 1'b0; settle();
    rd_chk(3'd2, 8'h0F, "R11 mark drops when input low");

    // broken mark run restarts the count
    rxmark_in = 1'b1; repeat (MARK_N - 10) @(negedge clk);
    rxmark_in = 1'b0; repeat (2) @(negedge clk);
    rxmark_in = 1'b1; repeat (MARK_N - 10) @(negedge clk);
    rd_chk(3'd2, 8'h0F, "R11 interrupted run not qualified");
    rxmark_in = 1'b0;
    settle();

    // R1 upper addresses read zero after traffic
    rd_chk(3'd5, 8'h00, "R1 address 5 reads zero");
    rd_chk(3'd0, model[0], "R1 address 0 holds control A");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule